// File: doc/BRIEF.md
# Disk Controller Auto-Powerdown Wake Control

This block sits in front of a disk controller's host register file and owns its automatic low-power state. An idle timer runs while the core reports that every powerdown condition holds. When the timer reaches its timeout, the block raises a powerdown flag. The timer is built from a clock-enable prescaler and a tick counter, sized so that the timeout equals 10 ms at the chosen clock.

While the core is asleep, the block sorts each host access into one of two classes. Some accesses end the low-power state:

- a read of the main status register,
- any access to the data port,
- a digital-output write that turns on a motor,
- a write that requests a software reset.

Every other access is served without waking the core. Reads return live status, and writes are stored and held for the core.

A hardware reset, or a software reset request, also produces a one-clock "run reset sequence" pulse. A wake caused by a register access produces no pulse and simply resumes operation.

Top module: `pdn_wake_ctrl`

## Requirements
- R1: After hardware reset, `pd_flag` is 0, `dout_q` is 0x00, `rate_q` is 0x02 and `cfg_q` is 0x02. `rst_seq` is high for exactly the first clock after reset is released.
- R2: With `idle_ok` held high and no waking access, `pd_flag` rises exactly TICK_DIV*TIMEOUT_TICKS clocks after the last timer reload. Reset, every waking access and every low `idle_ok` cycle reload the timer.
- R3: While `idle_ok` is low, the core does not enter powerdown. After `idle_ok` returns high, a full timeout window must pass before `pd_flag` rises.
- R4: A read at offset 4 (main status) wakes the core. `pd_flag` is 0 in the cycle of the access and `rst_seq` stays low.
- R5: A read or a write at offset 5 (data port) wakes the core in the cycle of the access, without a reset pulse.
- R6: A write at offset 2 (digital output) wakes the core only if any of data bits 7:4 (motor enables) is 1, or if bit 2 is 0. A read at offset 2 never wakes it.
- R7: A write at offset 2 with bit 2 = 0 (active-low soft reset), or at offset 4 with bit 7 = 1 (active-high soft reset), wakes the core. It also makes `rst_seq` high for exactly one clock, in the cycle after the write.
- R8: While powered down, these accesses leave `pd_flag` at 1: reads at offsets 0, 1, 2 and 7; writes at offset 7; writes at offset 4 with bit 7 = 0; and any access at offsets 3 and 6.
- R9: The read data appears on `bus_rdata` one clock after `bus_rd`. It is `stat_a_in` at offset 0, `stat_b_in` at 1, the stored digital-output value at 2, `msr_in` at 4, `data_in` at 5, `dir_in` at 7, and 0xFF at offsets 3 and 6.
- R10: Writes at offset 2, at offset 4 and at offset 7 are retained, even during powerdown, and appear on `dout_q`, `rate_q` and `cfg_q`. Bit 7 of `rate_q` is always 0, because the soft-reset bit clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 3 | Base-relative register offset |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| idle_ok | input | 1 | All powerdown conditions hold in the core |
| stat_a_in | input | 8 | Live value for status register A |
| stat_b_in | input | 8 | Live value for status register B |
| msr_in | input | 8 | Live main status value |
| data_in | input | 8 | Data port read value from the core |
| dir_in | input | 8 | Live digital input value |
| dout_q | output | 8 | Retained digital output register |
| rate_q | output | 8 | Retained data-rate select register |
| cfg_q | output | 8 | Retained configuration control register |
| pd_flag | output | 1 | Core is in powerdown |
| rst_seq | output | 1 | One-clock request to run the reset sequence |

## Verification
The bench builds the block with TICK_DIV = 4 and TIMEOUT_TICKS = 5, so the timeout window is 20 clocks instead of a million. This lets the bench count the exact edge on which `pd_flag` rises after reset, after each kind of wake, and after an idle drop. The short window also leaves time to walk every offset, in both directions, while the core is asleep. The prescaler and tick counter still take their counting path, because TICK_DIV above one selects the counting prescaler rather than the pass-through variant.

// File: rtl/pdn_wake_pkg.sv
package pdn_wake_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // base-relative offsets; behaviour depends on these values
  localparam logic [ADDR_W-1:0] OFS_STAT_A = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT_B = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_MAIN   = 3'd4;  // main status read / rate write
  localparam logic [ADDR_W-1:0] OFS_DPORT  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 3'd7;  // digital input read / config write

  // field positions
  localparam int MOTOR_LSB    = 4;
  localparam int NUM_MOTORS   = 4;
  localparam int DOUT_RST_BIT = 2;  // active low
  localparam int RATE_RST_BIT = 7;  // active high, self clearing

  localparam logic [DATA_W-1:0] DOUT_INIT = 8'h00;
  localparam logic [DATA_W-1:0] RATE_INIT = 8'h02;
  localparam logic [DATA_W-1:0] CFG_INIT  = 8'h02;
  localparam logic [DATA_W-1:0] OPEN_READ = 8'hFF;

  typedef struct packed {
    logic wake;     // access ends powerdown
    logic sw_rst;   // access requests the reset sequence
    logic wr_dout;
    logic wr_rate;
    logic wr_cfg;
  } acc_class_t;

endpackage

// File: rtl/pdn_acc_decode.sv
module pdn_acc_decode
  import pdn_wake_pkg::*;
#(
  parameter int MOTORS = NUM_MOTORS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [MOTORS-1:0] motor_bits,
  input  logic              dout_rst_n,
  input  logic              rate_rst,
  output acc_class_t        cls
);

  logic hit_dout, hit_main, hit_dport, hit_din;
  logic motor_on, soft_rst;

  always_comb begin
    hit_dout  = (addr == OFS_DOUT);
    hit_main  = (addr == OFS_MAIN);
    hit_dport = (addr == OFS_DPORT);
    hit_din   = (addr == OFS_DIN);

    motor_on = wr && hit_dout && (|motor_bits);
    soft_rst = (wr && hit_dout && !dout_rst_n) ||
               (wr && hit_main && rate_rst);

    cls.sw_rst  = soft_rst;
    cls.wake    = (rd && hit_main) ||
                  ((rd || wr) && hit_dport) ||
                  motor_on || soft_rst;
    cls.wr_dout = wr && hit_dout;
    cls.wr_rate = wr && hit_main;
    cls.wr_cfg  = wr && hit_din;
  end

endmodule

// File: rtl/pdn_idle_timer.sv
module pdn_idle_timer #(
  parameter int TICK_DIV      = 1000,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic clk,
  input  logic reload,
  input  logic run,
  output logic expire
);

  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

  logic             tick;
  logic [CNT_W-1:0] tick_cnt;

  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre;
      assign tick = run && (pre == PRE_W'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (reload)       pre <= '0;
        else if (tick)    pre <= '0;
        else if (run)     pre <= pre + 1'b1;
      end
    end else begin : g_direct
      assign tick = run;
    end
  endgenerate

  assign expire = tick && (tick_cnt == CNT_W'(TIMEOUT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (reload)       tick_cnt <= '0;
    else if (expire)  tick_cnt <= '0;
    else if (tick)    tick_cnt <= tick_cnt + 1'b1;
  end

endmodule

// File: rtl/pdn_regfile.sv
module pdn_regfile
  import pdn_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  acc_class_t        cls,
  input  logic [DATA_W-1:0] stat_a_in,
  input  logic [DATA_W-1:0] stat_b_in,
  input  logic [DATA_W-1:0] msr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] dir_in,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout_q,
  output logic [DATA_W-1:0] rate_q,
  output logic [DATA_W-1:0] cfg_q
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (addr)
      OFS_STAT_A: rd_mux = stat_a_in;
      OFS_STAT_B: rd_mux = stat_b_in;
      OFS_DOUT:   rd_mux = dout_q;
      OFS_MAIN:   rd_mux = msr_in;
      OFS_DPORT:  rd_mux = data_in;
      OFS_DIN:    rd_mux = dir_in;
      default:    rd_mux = OPEN_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      dout_q <= DOUT_INIT;
      rate_q <= RATE_INIT;
      cfg_q  <= CFG_INIT;
    end else begin
      if (rd) rdata <= rd_mux;
      if (cls.wr_dout) dout_q <= wdata;
      if (cls.wr_rate) begin
        rate_q               <= wdata;
        rate_q[RATE_RST_BIT] <= 1'b0;
      end
      if (cls.wr_cfg) cfg_q <= wdata;
    end
  end

endmodule

// File: rtl/pdn_wake_ctrl.sv
module pdn_wake_ctrl
  import pdn_wake_pkg::*;
#(
  parameter int TICK_DIV      = 1000,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              idle_ok,
  input  logic [DATA_W-1:0] stat_a_in,
  input  logic [DATA_W-1:0] stat_b_in,
  input  logic [DATA_W-1:0] msr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] dir_in,
  output logic [DATA_W-1:0] dout_q,
  output logic [DATA_W-1:0] rate_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic              pd_flag,
  output logic              rst_seq
);

  acc_class_t cls;
  logic       pd_q;
  logic       seq_pend;
  logic       expire;
  logic       timer_reload;

  pdn_acc_decode #(.MOTORS(NUM_MOTORS)) u_dec (
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .motor_bits (bus_wdata[MOTOR_LSB +: NUM_MOTORS]),
    .dout_rst_n (bus_wdata[DOUT_RST_BIT]),
    .rate_rst   (bus_wdata[RATE_RST_BIT]),
    .cls        (cls)
  );

  assign timer_reload = rst || cls.wake || !idle_ok;

  pdn_idle_timer #(
    .TICK_DIV      (TICK_DIV),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_tmr (
    .clk    (clk),
    .reload (timer_reload),
    .run    (idle_ok && !pd_q),
    .expire (expire)
  );

  pdn_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .cls       (cls),
    .stat_a_in (stat_a_in),
    .stat_b_in (stat_b_in),
    .msr_in    (msr_in),
    .data_in   (data_in),
    .dir_in    (dir_in),
    .rdata     (bus_rdata),
    .dout_q    (dout_q),
    .rate_q    (rate_q),
    .cfg_q     (cfg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q     <= 1'b0;
      seq_pend <= 1'b1;
      rst_seq  <= 1'b0;
    end else begin
      seq_pend <= 1'b0;
      rst_seq  <= seq_pend || cls.sw_rst;
      if (cls.wake)    pd_q <= 1'b0;
      else if (expire) pd_q <= 1'b1;
    end
  end

  // the waking access sees the core awake in its own cycle
  assign pd_flag = pd_q && !cls.wake;

endmodule

// File: rtl/pdn_wake_chk.sv
module pdn_wake_chk
  import pdn_wake_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              idle_ok,
  input logic [DATA_W-1:0] rate_q,
  input logic              pd_flag,
  input logic              pd_q,
  input logic              rst_seq
);

  assert_pulse_one_clock_R7: assert property (@(posedge clk) disable iff (rst)
    rst_seq |=> !rst_seq);

  assert_main_read_awake_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_MAIN) |-> !pd_flag);

  assert_dport_awake_R5: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr == OFS_DPORT) |-> !pd_flag);

  assert_no_sleep_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (!idle_ok && !pd_q) |=> !pd_q);

  assert_quiet_read_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (pd_flag && bus_rd && !bus_wr &&
     (bus_addr == OFS_STAT_A || bus_addr == OFS_STAT_B ||
      bus_addr == OFS_DOUT   || bus_addr == OFS_DIN)) |=> pd_q);

  assert_rate_bit_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !rate_q[RATE_RST_BIT]);

  assert_sleep_needs_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> $past(idle_ok));

endmodule

bind pdn_wake_ctrl pdn_wake_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .idle_ok  (idle_ok),
  .rate_q   (rate_q),
  .pd_flag  (pd_flag),
  .pd_q     (pd_q),
  .rst_seq  (rst_seq)
);

// File: tb/pdn_wake_ctrl_test.sv
`timescale 1ns/1ps
module pdn_wake_ctrl_test;

  localparam int DIV = 4;
  localparam int TMO = 5;
  localparam int WIN = DIV * TMO;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       idle_ok = 1'b1;
  logic [7:0] stat_a_in = 8'hA1;
  logic [7:0] stat_b_in = 8'hB2;
  logic [7:0] msr_in = 8'h80;
  logic [7:0] data_in = 8'h5A;
  logic [7:0] dir_in = 8'h7E;
  logic [7:0] dout_q, rate_q, cfg_q;
  logic       pd_flag, rst_seq;

  int checks = 0;
  int failures = 0;
  logic seen_pd;

  always #4 clk = ~clk;

  pdn_wake_ctrl #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_ok(idle_ok),
    .stat_a_in(stat_a_in), .stat_b_in(stat_b_in), .msr_in(msr_in),
    .data_in(data_in), .dir_in(dir_in), .dout_q(dout_q), .rate_q(rate_q),
    .cfg_q(cfg_q), .pd_flag(pd_flag), .rst_seq(rst_seq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; leaves at the negedge after the access edge
  task automatic access(input logic rd, input logic wr, input logic [2:0] a,
                        input logic [7:0] d);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1 seen_pd = pd_flag;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // called at the negedge right after a reload edge
  task automatic expect_window(input string req);
    repeat (WIN - 1) @(posedge clk);
    @(negedge clk);
    chk(req, pd_flag, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk(req, pd_flag, 1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 rst_seq first", rst_seq, 1'b1);
    chk("R1 pd_flag", pd_flag, 1'b0);
    chk("R1 dout_q", dout_q, 8'h00);
    chk("R1 rate_q", rate_q, 8'h02);
    chk("R1 cfg_q", cfg_q, 8'h02);
    @(posedge clk); @(negedge clk);
    chk("R1 rst_seq one clock", rst_seq, 1'b0);
    repeat (WIN - 3) @(posedge clk);
    @(negedge clk);
    chk("R2 before timeout", pd_flag, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R2 at timeout", pd_flag, 1'b1);
  endtask

  task automatic t_quiet;
    access(1, 0, 3'd0, 8'h00);
    chk("R8 stat A read keeps", seen_pd, 1'b1);
    chk("R9 stat A data", bus_rdata, 8'hA1);
    access(1, 0, 3'd1, 8'h00);
    chk("R9 stat B data", bus_rdata, 8'hB2);
    access(1, 0, 3'd7, 8'h00);
    chk("R9 dir data", bus_rdata, 8'h7E);
    access(0, 1, 3'd7, 8'h03);
    chk("R8 cfg write keeps", seen_pd, 1'b1);
    access(0, 1, 3'd4, 8'h01);
    chk("R8 rate write keeps", seen_pd, 1'b1);
    access(0, 1, 3'd2, 8'h0C);
    chk("R6 dout write no motor keeps", seen_pd, 1'b1);
    access(1, 0, 3'd2, 8'h00);
    chk("R6 dout read keeps", seen_pd, 1'b1);
    chk("R10 dout retained", bus_rdata, 8'h0C);
    access(0, 1, 3'd3, 8'h00);
    access(1, 0, 3'd6, 8'h00);
    chk("R9 open offset", bus_rdata, 8'hFF);
    chk("R8 unmapped keeps", pd_flag, 1'b1);
    chk("R10 cfg retained", cfg_q, 8'h03);
    chk("R10 rate retained", rate_q, 8'h01);
    chk("R8 no reset pulse", rst_seq, 1'b0);
  endtask

  task automatic t_msr_wake;
    access(1, 0, 3'd4, 8'h00);
    chk("R4 awake in cycle", seen_pd, 1'b0);
    chk("R4 data", bus_rdata, 8'h80);
    chk("R4 no reset pulse", rst_seq, 1'b0);
    expect_window("R2 after MSR wake");
  endtask

  task automatic t_data_wake;
    access(1, 0, 3'd5, 8'h00);
    chk("R5 read awake", seen_pd, 1'b0);
    chk("R5 data", bus_rdata, 8'h5A);
    expect_window("R5 read window");
    access(0, 1, 3'd5, 8'h33);
    chk("R5 write awake", seen_pd, 1'b0);
    chk("R5 no reset pulse", rst_seq, 1'b0);
    expect_window("R5 write window");
  endtask

  task automatic t_motor;
    access(0, 1, 3'd2, 8'h1C);
    chk("R6 motor wake", seen_pd, 1'b0);
    chk("R6 no reset pulse", rst_seq, 1'b0);
    chk("R10 dout motor", dout_q, 8'h1C);
    expect_window("R6 window");
  endtask

  task automatic t_soft_reset;
    access(0, 1, 3'd2, 8'h00);
    chk("R7 dout reset wake", seen_pd, 1'b0);
    chk("R7 dout pulse", rst_seq, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R7 dout pulse ends", rst_seq, 1'b0);
    repeat (WIN - 2) @(posedge clk);
    @(negedge clk);
    chk("R7 window", pd_flag, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7 asleep", pd_flag, 1'b1);
    access(0, 1, 3'd4, 8'h82);
    chk("R7 rate reset wake", seen_pd, 1'b0);
    chk("R7 rate pulse", rst_seq, 1'b1);
    chk("R10 rate bit clears", rate_q, 8'h02);
    @(posedge clk); @(negedge clk);
    chk("R7 rate pulse ends", rst_seq, 1'b0);
  endtask

  task automatic t_idle;
    idle_ok = 1'b0;
    repeat (3 * WIN) @(posedge clk);
    @(negedge clk);
    chk("R3 busy stays awake", pd_flag, 1'b0);
    idle_ok = 1'b1;
    expect_window("R3 full window after idle");
  endtask

  initial begin
    #(8 * 50000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_quiet();
    t_msr_wake();
    t_data_wake();
    t_motor();
    t_soft_reset();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule